// File: doc/BRIEF.md
# Outstanding Completion Tracker with Status

This block sits beside the request scheduler of a DMA channel controller. It counts the transfer requests that asked for a completion report and are still waiting for one from the transfer engines. A request counts when its completion-interrupt-enable flag or its completion-chaining-enable flag is set. Each valid completion code that comes back lowers the count.

The count saturates at 63. While it stays there, the block lowers its submit-permitted output so that the scheduler holds new requests back. When a completion return arrives, the count drops below the limit and the scheduler can submit again.

The block also drives a read-only 32-bit status word. The word holds a registered activity flag for each of four request queues, the outstanding count, and a general activity bit. It has no write path, so nothing can alter it from outside. A sticky error output records any completion return that arrived with nothing outstanding.

Top module: `cmpl_track_stat`

## Requirements
- R1: After reset, status_o is 0, err_underflow_o is 0 and submit_ready_o is 1.
- R2: An accepted submit (submit_i high while submit_ready_o is high) raises the count in status_o[13:8] by one at the next rising edge if submit_irq_en_i or submit_chain_en_i is 1. A submit with both flags 0 leaves the count unchanged.
- R3: A ret_valid_i pulse with the count nonzero and no counted submit in the same cycle lowers the count by one.
- R4: A counted accepted submit and a ret_valid_i in the same cycle leave the count unchanged. This holds at count 0 and at count 63, and neither case sets the error.
- R5: submit_ready_o is 0 exactly when the count is 63 and ret_valid_i is 0, combinationally. A submit given while submit_ready_o is 0 is ignored, and the count stays 63.
- R6: A ret_valid_i at count 0 without a counted submit is ignored, so the count stays 0. It also sets err_underflow_o, which then stays 1 until reset.
- R7: status_o[16+n] equals q_busy_i[n] as sampled at the previous rising edge, for n = 0..3.
- R8: status_o[4] is 1 exactly when the count is nonzero or any of status_o[19:16] is 1.
- R9: status_o bits 31:20, 15:14, 7:5 and 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| submit_i | input | 1 | Request submit strobe |
| submit_irq_en_i | input | 1 | Submitted request asks for a completion interrupt |
| submit_chain_en_i | input | 1 | Submitted request asks for completion chaining |
| ret_valid_i | input | 1 | Valid completion code returned by a transfer engine |
| q_busy_i | input | 4 | Per-queue occupancy, bit n set when queue n holds a request |
| submit_ready_o | output | 1 | Submission permitted in this cycle |
| status_o | output | 32 | Read-only status word |
| err_underflow_o | output | 1 | Sticky flag: a return arrived with nothing outstanding |

## Verification
Submission and completion return can occur in the same cycle. The bench provokes this case at three counts: in the middle of the range, at 0, and at 63, where the saturated counter has lowered submit-permitted. Before the edge, it checks that submit-permitted has gone high again combinationally because of the return. After the edge, it checks that the count has not moved and that the underflow flag has stayed clear. A lone return at count 0 and a lone submit at 63 are then applied to confirm that each is ignored.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int STAT_W  = 32;
  localparam int CNT_LSB = 8;
  localparam int Q_LSB   = 16;
  localparam int ACT_BIT = 4;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/cts_ctrl.sv
module cts_ctrl
  import cts_pkg::*;
(
  input  logic    submit_i,
  input  logic    irq_en_i,
  input  logic    chain_en_i,
  input  logic    ret_valid_i,
  input  logic    at_max_i,
  input  logic    at_zero_i,
  output logic    ready_o,
  output cnt_op_e op_o,
  output logic    uflow_o
);
  logic inc;

  // a return frees a slot in the same cycle, so it re-opens the gate
  assign ready_o = !at_max_i || ret_valid_i;
  assign inc     = submit_i && ready_o && (irq_en_i || chain_en_i);
  assign uflow_o = ret_valid_i && at_zero_i && !inc;

  always_comb begin
    op_o = CNT_HOLD;
    if (inc && !ret_valid_i)                   op_o = CNT_UP;
    else if (!inc && ret_valid_i && !at_zero_i) op_o = CNT_DOWN;
  end
endmodule

// File: rtl/cts_counter.sv
module cts_counter
  import cts_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  input  logic             uflow_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o,
  output logic             at_zero_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (op_i)
        CNT_UP:   cnt_q <= cnt_q + 1'b1;
        CNT_DOWN: cnt_q <= cnt_q - 1'b1;
        default:  cnt_q <= cnt_q;
      endcase
      if (uflow_i) err_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign at_max_o  = (cnt_q == CNT_MAX);
  assign at_zero_o = (cnt_q == '0);
  assign err_o     = err_q;
endmodule

// File: rtl/cts_qflags.sv
module cts_qflags #(
  parameter int N_Q = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_Q-1:0] busy_i,
  output logic [N_Q-1:0] flag_o
);
  for (genvar g = 0; g < N_Q; g++) begin : g_q
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= busy_i[g];
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/cts_status_pack.sv
module cts_status_pack
  import cts_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int N_Q   = 4
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [N_Q-1:0]    qflag_i,
  output logic [STAT_W-1:0] word_o
);
  always_comb begin
    word_o                   = '0;
    word_o[CNT_LSB +: CNT_W] = cnt_i;
    word_o[Q_LSB +: N_Q]     = qflag_i;
    word_o[ACT_BIT]          = (|cnt_i) || (|qflag_i);
  end
endmodule

// File: rtl/cmpl_track_stat.sv
module cmpl_track_stat
  import cts_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int N_Q   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              submit_i,
  input  logic              submit_irq_en_i,
  input  logic              submit_chain_en_i,
  input  logic              ret_valid_i,
  input  logic [N_Q-1:0]    q_busy_i,
  output logic              submit_ready_o,
  output logic [STAT_W-1:0] status_o,
  output logic              err_underflow_o
);
  cnt_op_e          op;
  logic             uflow, at_max, at_zero;
  logic [CNT_W-1:0] cnt;
  logic [N_Q-1:0]   qflag;

  cts_ctrl u_ctrl (
    .submit_i   (submit_i),
    .irq_en_i   (submit_irq_en_i),
    .chain_en_i (submit_chain_en_i),
    .ret_valid_i(ret_valid_i),
    .at_max_i   (at_max),
    .at_zero_i  (at_zero),
    .ready_o    (submit_ready_o),
    .op_o       (op),
    .uflow_o    (uflow)
  );

  cts_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .uflow_i  (uflow),
    .cnt_o    (cnt),
    .at_max_o (at_max),
    .at_zero_o(at_zero),
    .err_o    (err_underflow_o)
  );

  cts_qflags #(.N_Q(N_Q)) u_qf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(q_busy_i),
    .flag_o(qflag)
  );

  cts_status_pack #(.CNT_W(CNT_W), .N_Q(N_Q)) u_pack (
    .cnt_i  (cnt),
    .qflag_i(qflag),
    .word_o (status_o)
  );
endmodule

// File: rtl/cts_checker.sv
module cts_checker
  import cts_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int N_Q   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              submit_i,
  input logic              submit_irq_en_i,
  input logic              submit_chain_en_i,
  input logic              ret_valid_i,
  input logic [N_Q-1:0]    q_busy_i,
  input logic              submit_ready_o,
  input logic [STAT_W-1:0] status_o,
  input logic              err_underflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [STAT_W-1:0] USED_MASK =
    ((STAT_W'(1) << ACT_BIT)) |
    (((STAT_W'(1) << CNT_W) - 1) << CNT_LSB) |
    (((STAT_W'(1) << N_Q) - 1) << Q_LSB);

  logic [CNT_W-1:0] cnt;
  logic             cnt_sub;
  assign cnt     = status_o[CNT_LSB +: CNT_W];
  assign cnt_sub = submit_i && submit_ready_o && (submit_irq_en_i || submit_chain_en_i);

  assert_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_sub && !ret_valid_i) |=> cnt == $past(cnt) + 1'b1);

  assert_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !cnt_sub && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  assert_same_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_sub && ret_valid_i) |=> $stable(cnt));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_MAX && !ret_valid_i) |-> !submit_ready_o);

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !cnt_sub && cnt == '0) |=> (cnt == '0 && err_underflow_o));

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_underflow_o |=> err_underflow_o);

  assert_qflag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    submit_ready_o || !submit_ready_o |=> status_o[Q_LSB +: N_Q] == $past(q_busy_i));

  assert_active_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[ACT_BIT] == ((cnt != '0) || (status_o[Q_LSB +: N_Q] != '0)));

  assert_reserved_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~USED_MASK) == '0);
endmodule

bind cmpl_track_stat cts_checker #(.CNT_W(CNT_W), .N_Q(N_Q)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .submit_i         (submit_i),
  .submit_irq_en_i  (submit_irq_en_i),
  .submit_chain_en_i(submit_chain_en_i),
  .ret_valid_i      (ret_valid_i),
  .q_busy_i         (q_busy_i),
  .submit_ready_o   (submit_ready_o),
  .status_o         (status_o),
  .err_underflow_o  (err_underflow_o)
);

// File: tb/sim_cmpl_track_stat.sv
module sim_cmpl_track_stat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub = 1'b0, irq = 1'b0, chn = 1'b0, ret = 1'b0;
  logic [3:0]  q = '0;
  logic        rdy, err;
  logic [31:0] st;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  localparam logic [31:0] RSV_MASK = 32'hFFF0_C0EF;

  // {sub, irq, chn, ret, q[3:0], exp_cnt[5:0], exp_q[3:0]}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 4'b0001, 6'd1, 4'b0001},
    {1'b1, 1'b0, 1'b1, 1'b0, 4'b0000, 6'd2, 4'b0000},
    {1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, 6'd2, 4'b1000},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 6'd1, 4'b0000},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'b0000, 6'd1, 4'b0000},
    {1'b1, 1'b1, 1'b1, 1'b0, 4'b0110, 6'd2, 4'b0110},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'b0110, 6'd1, 4'b0110},
    {1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, 6'd0, 4'b0000}
  };

  always #5 clk = ~clk;

  cmpl_track_stat u0 (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .submit_i         (sub),
    .submit_irq_en_i  (irq),
    .submit_chain_en_i(chn),
    .ret_valid_i      (ret),
    .q_busy_i         (q),
    .submit_ready_o   (rdy),
    .status_o         (st),
    .err_underflow_o  (err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic i, input logic c, input logic r);
    @(negedge clk);
    sub = s; irq = i; chn = c; ret = r;
    @(posedge clk);
    #1;
    sub = 1'b0; irq = 1'b0; chn = 1'b0; ret = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 status", st, 32'h0);
    check("R1 ready", {31'b0, rdy}, 32'h1);
    check("R1 err", {31'b0, err}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {sub, irq, chn, ret, q} = VEC[k][17:10];
      @(posedge clk);
      #1;
      check($sformatf("R2/R3/R4 cnt v%0d", k), {26'b0, st[13:8]}, {26'b0, VEC[k][9:4]});
      check($sformatf("R7 qflags v%0d", k), {28'b0, st[19:16]}, {28'b0, VEC[k][3:0]});
      check($sformatf("R8 active v%0d", k), {31'b0, st[4]},
            {31'b0, (VEC[k][9:4] != 0) || (VEC[k][3:0] != 0)});
      check($sformatf("R9 reserved v%0d", k), st & RSV_MASK, 32'h0);
    end
    @(negedge clk);
    sub = 1'b0; irq = 1'b0; chn = 1'b0; ret = 1'b0; q = '0;
    @(posedge clk); #1;

    // R4 at count 0: counted submit with return
    step(1'b1, 1'b1, 1'b0, 1'b1);
    check("R4 zero simul cnt", {26'b0, st[13:8]}, 32'd0);
    check("R4 zero simul err", {31'b0, err}, 32'h0);

    // fill to saturation
    for (int k = 0; k < 63; k++) step(1'b1, 1'b0, 1'b1, 1'b0);
    check("R2 fill cnt", {26'b0, st[13:8]}, 32'd63);
    check("R5 ready low", {31'b0, rdy}, 32'h0);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    check("R5 ignored submit", {26'b0, st[13:8]}, 32'd63);

    // R5 combinational re-open, R4 at 63
    @(negedge clk);
    sub = 1'b1; irq = 1'b1; ret = 1'b1;
    #1;
    check("R5 ready with ret", {31'b0, rdy}, 32'h1);
    @(posedge clk); #1;
    sub = 1'b0; irq = 1'b0; ret = 1'b0;
    check("R4 max simul cnt", {26'b0, st[13:8]}, 32'd63);

    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 dec from max", {26'b0, st[13:8]}, 32'd62);
    check("R5 ready again", {31'b0, rdy}, 32'h1);

    for (int k = 0; k < 62; k++) step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 drained", {26'b0, st[13:8]}, 32'd0);
    check("R8 idle", {31'b0, st[4]}, 32'h0);
    check("R6 err clear", {31'b0, err}, 32'h0);

    // R6 underflow and stickiness
    step(1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 uflow cnt", {26'b0, st[13:8]}, 32'd0);
    check("R6 uflow err", {31'b0, err}, 32'h1);
    step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R6 err sticky", {31'b0, err}, 32'h1);
    check("R2 after err", {26'b0, st[13:8]}, 32'd1);
    check("R9 final", st & RSV_MASK, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule